// File: doc/BRIEF.md
# Accumulator CPU core

An 8-bit accumulator processor with its own 256-word by 16-bit unified memory. Code and data share that memory. Every instruction fills one word: the top nibble selects the operation, the low byte is either an immediate constant or a memory address, and the four bits between them are ignored. The core can add, subtract, AND, or move an immediate value into the accumulator. It can load a memory word, add a memory word to the accumulator, and store the accumulator to memory. It can also jump always, jump when the accumulator is zero, or jump when it is non-zero. A store to the top address (0xFF) also drives an 8-bit output port. Because code and data share one memory, a program can rewrite its own operands.

Before execution, a program is written into memory through a valid/ready load stream. A word is accepted on every rising edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is high only while the core is idle after reset and before `run` is seen. A loader with words still pending must hold `ld_valid`, `ld_addr` and `ld_data` steady until `ld_ready` returns, which happens only after the next reset. Raising `run` starts execution from address 0. After that, `run` is not looked at again until the next reset. Reset does not clear the memory.

Top module: `acc_core`

## Requirements
- R1: Reset clears the program counter, the accumulator, `out_port` and `out_stb`, and puts the core in an idle state with `ld_ready` high. Execution begins at address 0 once `run` is high.
- R2: A load word is written to `ld_addr` on each edge where `ld_valid` and `ld_ready` are both high. `ld_ready` goes low once execution starts and stays low until reset.
- R3: Instruction bits 15:12 hold the opcode and bits 7:0 hold the operand. Bits 11:8 have no effect on any instruction.
- R4: The immediate opcodes are 0x0 (acc = k), 0x1 (acc = acc + k), 0x2 (acc = acc - k) and 0x3 (acc = acc AND k). Results wrap modulo 256.
- R5: Opcode 0x4 loads the low byte of the addressed word into the accumulator. Opcode 0x6 adds that low byte to the accumulator, modulo 256. The high byte of the word is ignored.
- R6: Opcode 0x5 writes the accumulator into the low byte of the addressed word and zero into its high byte.
- R7: A store to address 0xFF sets `out_port` to the accumulator and raises `out_stb` for exactly one cycle. `out_port` changes at no other time.
- R8: Opcode 0x8 jumps to the operand address. Opcode 0x9 jumps only when the accumulator is zero. Opcode 0xA jumps only when it is non-zero. A jump that is not taken advances to the next word.
- R9: A word rewritten by a store is fetched with its new contents when it is next executed.
- R10: Opcodes 0x7 and 0xB to 0xF leave the accumulator, memory and output unchanged and advance the program counter by one.
- R11: Every instruction takes 3 cycles, except 0x4 and 0x6, which take 4. The first instruction is fetched on the cycle after `run` is sampled. So a program `move; store 0xFF` raises `out_stb` 7 edges after `run` is first sampled, and `load; store 0xFF` raises it after 8 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Start execution; sampled only while idle |
| ld_valid | input | 1 | Load stream word present |
| ld_ready | output | 1 | Load stream accepts a word (idle only) |
| ld_addr | input | 8 | Memory address of the load word |
| ld_data | input | 16 | Instruction or data word to load |
| out_port | output | 8 | Output port, last value stored to 0xFF |
| out_stb | output | 1 | One-cycle pulse when `out_port` is written |

## Verification
The assertions assume that `rst` is held for at least one edge before any check matters. They also assume that `ld_valid` is raised only while the core is idle, so loader writes never compete with the core's own stores. The stimulus follows both rules: every program is written through the load stream between a reset and the rise of `run`. Each program ends in a jump to itself, so execution never runs into memory words that were not loaded. The sweeps cover 16x16 operand pairs for the immediate arithmetic, every accumulator value for both conditional jumps, and every undefined opcode.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_MOVE  = 4'h0;
  localparam logic [OPW-1:0] OP_ADD   = 4'h1;
  localparam logic [OPW-1:0] OP_SUB   = 4'h2;
  localparam logic [OPW-1:0] OP_AND   = 4'h3;
  localparam logic [OPW-1:0] OP_LOAD  = 4'h4;
  localparam logic [OPW-1:0] OP_STORE = 4'h5;
  localparam logic [OPW-1:0] OP_ADDM  = 4'h6;
  localparam logic [OPW-1:0] OP_JMP   = 4'h8;
  localparam logic [OPW-1:0] OP_JZ    = 4'h9;
  localparam logic [OPW-1:0] OP_JNZ   = 4'hA;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_MEMRD
  } state_t;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_AND
  } alu_t;

  typedef enum logic [1:0] {
    C_ALWAYS,
    C_ZERO,
    C_NZERO
  } cond_t;

  typedef struct packed {
    logic  acc_imm;  // accumulator written in EXEC from the immediate path
    logic  acc_mem;  // accumulator written in MEMRD from memory
    alu_t  alu;
    logic  mem_wr;
    logic  jump;
    cond_t cond;
  } ctrl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [OPW-1:0] op,
  output ctrl_t          ctrl
);

  always_comb begin
    ctrl = '{acc_imm: 1'b0, acc_mem: 1'b0, alu: ALU_PASS,
             mem_wr: 1'b0, jump: 1'b0, cond: C_ALWAYS};
    case (op)
      OP_MOVE:  begin ctrl.acc_imm = 1'b1; ctrl.alu = ALU_PASS; end
      OP_ADD:   begin ctrl.acc_imm = 1'b1; ctrl.alu = ALU_ADD;  end
      OP_SUB:   begin ctrl.acc_imm = 1'b1; ctrl.alu = ALU_SUB;  end
      OP_AND:   begin ctrl.acc_imm = 1'b1; ctrl.alu = ALU_AND;  end
      OP_LOAD:  begin ctrl.acc_mem = 1'b1; ctrl.alu = ALU_PASS; end
      OP_ADDM:  begin ctrl.acc_mem = 1'b1; ctrl.alu = ALU_ADD;  end
      OP_STORE: ctrl.mem_wr = 1'b1;
      OP_JMP:   begin ctrl.jump = 1'b1; ctrl.cond = C_ALWAYS; end
      OP_JZ:    begin ctrl.jump = 1'b1; ctrl.cond = C_ZERO;   end
      OP_JNZ:   begin ctrl.jump = 1'b1; ctrl.cond = C_NZERO;  end
      default:  ;  // undefined opcodes behave as no-ops
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_t          sel,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  always_comb begin
    case (sel)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      default: y = b;
    endcase
  end

endmodule

// File: rtl/acc_ram.sv
module acc_ram #(
  parameter int AW = 8,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [IW-1:0] ld_data,
  output logic [AW-1:0] out_port,
  output logic          out_stb
);

  // The operand field doubles as data value and address, so both share AW.
  localparam int DW = AW;
  localparam int HW = IW - AW;
  localparam logic [AW-1:0] PORT_ADDR = '1;

  state_t         state;
  logic [AW-1:0]  pc;
  logic [DW-1:0]  acc;
  logic [IW-1:0]  ir;
  logic [IW-1:0]  rdata;
  logic [OPW-1:0] op;
  logic [AW-1:0]  opnd;
  ctrl_t          ctrl;
  logic [DW-1:0]  alu_b;
  logic [DW-1:0]  alu_y;
  logic           take;
  logic           cpu_we;
  logic           ld_we;
  logic [AW-1:0]  raddr;
  logic [AW-1:0]  waddr;
  logic [IW-1:0]  wdata;
  logic           unused_fields;

  assign op   = ir[IW-1 -: OPW];
  assign opnd = ir[AW-1:0];
  assign unused_fields = ^{ir[IW-OPW-1:AW], rdata[IW-1:AW]};

  acc_decode u_dec (.op(op), .ctrl(ctrl));

  assign alu_b = (state == ST_MEMRD) ? rdata[DW-1:0] : opnd;

  acc_alu #(.DW(DW)) u_alu (.sel(ctrl.alu), .a(acc), .b(alu_b), .y(alu_y));

  always_comb begin
    case (ctrl.cond)
      C_ZERO:  take = (acc == '0);
      C_NZERO: take = (acc != '0);
      default: take = 1'b1;
    endcase
  end

  assign ld_ready = (state == ST_IDLE);
  assign ld_we    = ld_valid && ld_ready;
  assign cpu_we   = (state == ST_EXEC) && ctrl.mem_wr;
  assign raddr    = (state == ST_EXEC) ? opnd : pc;
  assign waddr    = cpu_we ? opnd : ld_addr;
  assign wdata    = cpu_we ? {{HW{1'b0}}, acc} : ld_data;

  acc_ram #(.AW(AW), .W(IW)) u_ram (
    .clk(clk), .we(cpu_we || ld_we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pc       <= '0;
      acc      <= '0;
      ir       <= '0;
      out_port <= '0;
      out_stb  <= 1'b0;
    end else begin
      out_stb <= 1'b0;
      case (state)
        ST_IDLE:   if (run) state <= ST_FETCH;
        ST_FETCH:  state <= ST_DECODE;
        ST_DECODE: begin
          ir    <= rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (ctrl.acc_mem) begin
            state <= ST_MEMRD;
          end else begin
            if (ctrl.acc_imm) acc <= alu_y;
            if (ctrl.mem_wr && opnd == PORT_ADDR) begin
              out_port <= acc;
              out_stb  <= 1'b1;
            end
            pc    <= (ctrl.jump && take) ? opnd : pc + 1'b1;
            state <= ST_FETCH;
          end
        end
        ST_MEMRD: begin
          acc   <= alu_y;
          pc    <= pc + 1'b1;
          state <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: an unconditional jump lands on its operand
  a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && op == OP_JMP) |=> (pc == $past(opnd)));

  // R10: undefined opcodes advance the counter and keep the accumulator
  a_r10_nop_advance: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && (op == 4'h7 || op >= 4'hB))
      |=> (pc == $past(pc) + 1'b1) && (acc == $past(acc)));

  // R7: the strobe is a single-cycle pulse
  a_r7_stb_pulse: assert property (@(posedge clk) disable iff (rst)
    out_stb |=> !out_stb);

  // R7: the port only moves together with its strobe
  a_r7_port_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_port) |-> out_stb);

  // R2: loader and core never write memory in the same cycle
  a_r2_single_writer: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_we, ld_we}));

  // R11: a fetch is always followed by a decode
  a_r11_fetch_order: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state == ST_DECODE));

  // R5: the memory-operand cycle always returns to fetch
  a_r5_memrd_exit: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEMRD) |=> (state == ST_FETCH));

endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [7:0]  out_port;
  logic        out_stb;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] obs [16];
  int nobs;

  always #4 clk = ~clk;

  acc_core u0 (
    .clk(clk), .rst(rst), .run(run), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .out_port(out_port), .out_stb(out_stb)
  );

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [7:0] v);
    return {op, 4'h0, v};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    run = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_addr  = a;
    ld_data  = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic go(input int cycles);
    nobs = 0;
    @(negedge clk);
    run = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (out_stb && nobs < 16) begin
        obs[nobs] = out_port;
        nobs++;
      end
    end
    run = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_up();
  end

  initial begin
    do_reset();
    // R1: reset state
    check(out_port == 8'h00 && !out_stb, "R1 reset outputs", {out_port, 7'h0, out_stb}, 0);
    check(ld_ready == 1'b1, "R1 ready after reset", ld_ready, 1);

    // R11/R1: latency of move+store, first fetch at address 0
    put(8'h00, ins(4'h0, 8'h05));
    put(8'h01, ins(4'h5, 8'hFF));
    put(8'h02, ins(4'h8, 8'h02));
    begin
      int n;
      n = 0;
      @(negedge clk);
      run = 1'b1;
      while (n < 50) begin
        @(negedge clk);
        n++;
        if (out_stb) break;
      end
      check(n == 7, "R11 move-store latency", n, 7);
      check(out_port == 8'h05, "R1 first fetch at 0", out_port, 5);
      check(ld_ready == 1'b0, "R2 ready low while running", ld_ready, 0);
      run = 1'b0;
    end

    // R11/R5: load latency, high byte ignored
    do_reset();
    check(out_port == 8'h00, "R1 port cleared by reset", out_port, 0);
    put(8'h10, 16'hC733);
    put(8'h00, ins(4'h4, 8'h10));
    put(8'h01, ins(4'h5, 8'hFF));
    put(8'h02, ins(4'h8, 8'h02));
    begin
      int n;
      n = 0;
      @(negedge clk);
      run = 1'b1;
      while (n < 50) begin
        @(negedge clk);
        n++;
        if (out_stb) break;
      end
      check(n == 8, "R11 load-store latency", n, 8);
      check(out_port == 8'h33, "R5 load low byte", out_port, 8'h33);
      run = 1'b0;
    end

    // R4/R3: immediate arithmetic sweep with junk in bits 11:8
    for (int ai = 0; ai < 16; ai++) begin
      for (int bi = 0; bi < 16; bi++) begin
        logic [7:0] a, b;
        logic [3:0] junk;
        a = 8'(ai * 17);
        b = 8'(bi * 17);
        junk = 4'(ai ^ bi);
        do_reset();
        put(8'd0,  {4'h0, junk, a});
        put(8'd1,  ins(4'h5, 8'hFF));
        put(8'd2,  {4'h1, junk, b});
        put(8'd3,  ins(4'h5, 8'hFF));
        put(8'd4,  ins(4'h0, a));
        put(8'd5,  {4'h2, junk, b});
        put(8'd6,  ins(4'h5, 8'hFF));
        put(8'd7,  ins(4'h0, a));
        put(8'd8,  {4'h3, junk, b});
        put(8'd9,  ins(4'h5, 8'hFF));
        put(8'd10, ins(4'h8, 8'd10));
        go(40);
        check(nobs == 4, "R4 output count", nobs, 4);
        check(obs[0] == a, "R4 move", obs[0], a);
        check(obs[1] == 8'(a + b), "R4 add wrap", obs[1], 8'(a + b));
        check(obs[2] == 8'(a - b), "R4 sub wrap", obs[2], 8'(a - b));
        check(obs[3] == (a & b), "R3 and with junk nibble", obs[3], a & b);
      end
    end

    // R5/R6: memory operands and zero-filled store
    for (int v = 0; v < 256; v += 5) begin
      logic [7:0] d;
      d = 8'(2 * v);
      do_reset();
      put(8'h90, {8'hA5, 8'(v)});
      put(8'h91, 16'hF0EE);
      put(8'h92, ins(4'h5, 8'hFF));
      put(8'h93, ins(4'h8, 8'h93));
      put(8'd0, ins(4'h4, 8'h90));
      put(8'd1, ins(4'h5, 8'hFF));
      put(8'd2, ins(4'h6, 8'h90));
      put(8'd3, ins(4'h5, 8'hFF));
      put(8'd4, ins(4'h5, 8'h91));
      put(8'd5, ins(4'h0, 8'h00));
      put(8'd6, ins(4'h4, 8'h91));
      put(8'd7, ins(4'h5, 8'hFF));
      put(8'd8, ins(4'h0, 8'h00));
      put(8'd9, ins(4'h8, 8'h91));
      go(70);
      check(nobs == 4, "R5 output count", nobs, 4);
      check(obs[0] == 8'(v), "R5 load", obs[0], v);
      check(obs[1] == d, "R5 addm", obs[1], d);
      check(obs[2] == d, "R6 store then load", obs[2], d);
      check(obs[3] == d, "R6 high byte zero (runs as move)", obs[3], d);
    end

    // R8: conditional jumps over every accumulator value
    for (int k = 0; k < 2; k++) begin
      for (int a = 0; a < 256; a++) begin
        logic [7:0] exp;
        bit tk;
        tk = (k == 0) ? (a == 0) : (a != 0);
        exp = tk ? 8'h22 : 8'h11;
        do_reset();
        put(8'd0, ins(4'h0, 8'(a)));
        put(8'd1, ins((k == 0) ? 4'h9 : 4'hA, 8'd5));
        put(8'd2, ins(4'h0, 8'h11));
        put(8'd3, ins(4'h5, 8'hFF));
        put(8'd4, ins(4'h8, 8'd4));
        put(8'd5, ins(4'h0, 8'h22));
        put(8'd6, ins(4'h5, 8'hFF));
        put(8'd7, ins(4'h8, 8'd7));
        go(30);
        check(nobs == 1 && obs[0] == exp, (k == 0) ? "R8 jump-if-zero" : "R8 jump-if-nonzero",
              obs[0], exp);
      end
    end

    // R10: undefined opcodes are no-ops
    for (int o = 7; o < 16; o++) begin
      if (o >= 8 && o <= 10) continue;
      do_reset();
      put(8'd0, ins(4'h0, 8'h42));
      put(8'd1, {4'(o), 4'hF, 8'h00});
      put(8'd2, ins(4'h5, 8'hFF));
      put(8'd3, ins(4'h8, 8'd3));
      go(30);
      check(nobs == 1 && obs[0] == 8'h42, "R10 undefined opcode no-op", obs[0], 8'h42);
    end

    // R9: self-modifying code
    do_reset();
    put(8'd0, ins(4'h0, 8'h37));
    put(8'd1, ins(4'h5, 8'd4));
    put(8'd2, ins(4'h0, 8'h00));
    put(8'd3, ins(4'h8, 8'd4));
    put(8'd4, ins(4'h5, 8'hFF));
    put(8'd5, ins(4'h5, 8'hFF));
    put(8'd6, ins(4'h8, 8'd6));
    go(40);
    check(nobs == 1, "R9 rewritten word output count", nobs, 1);
    check(obs[0] == 8'h37, "R9 rewritten word fetched", obs[0], 8'h37);

    finish_up();
  end

endmodule